// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

The walker turns a linked-in-memory list of transfer descriptors into a stream of (address, length) segments for a downstream data mover. Software, or a neighbouring engine, places the list in memory and pulses `start_i` together with the byte address of its first entry. The walker reads each descriptor through a single-word memory read port, one word at a time, and hands the decoded segment to the consumer with a valid/ready handshake. The data transfer of each segment belongs to the consumer.

Every descriptor occupies eight bytes: a 32-bit little-endian length word first, then a 32-bit little-endian address word. The top bit of the length word ends the list. If the programmed entry limit is used up without meeting that marker, the walk ends with an error pulse and the consumer is expected to drop the whole request. A successful walk ends with a done pulse.

Top module: `sgl_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `mem_req_valid_o`, `seg_valid_o`, `done_o` and `error_o` are all low.
- R2: A walk started with base B reads entry k's length word at byte address B+8k and its address word at B+4+8k (modulo 2^ADDR_W), length word first; each word is used as its little-endian 32-bit value without byte swapping.
- R3: The emitted segment length equals bits [27:0] of the length word and the emitted segment address equals bits [30:0] of the address word; bits [30:28] of the length word and bit 31 of the address word have no effect on the segment.
- R4: Bit 31 of the length word marks the final entry and is presented on `seg_last_o`; the cycle after that segment is accepted, `done_o` is high for exactly one cycle and no further descriptor word is requested.
- R5: Segments leave in list order, one per descriptor; while `seg_valid_o` is high and `seg_ready_i` low the segment fields stay unchanged and no memory request is raised.
- R6: A descriptor whose masked length is zero still produces a segment with `seg_len_o` equal to 0.
- R7: With entry limit M (parameter `MAX_ENTRIES`), if M segments are accepted none of which carries the final mark, `error_o` is high for exactly one cycle in the cycle after the M-th acceptance, `done_o` stays low, and descriptor M+1 is never read.
- R8: A `start_i` pulse arriving while a walk is in progress is ignored: the running walk keeps its own address sequence and no second walk follows.
- R9: At most one memory read is outstanding: after a request is accepted no new request is raised until its response arrives, and a request that is not yet accepted keeps its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a walk; taken only while idle |
| base_addr_i | input | ADDR_W | Byte address of the first descriptor, sampled with `start_i` |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | ADDR_W | Byte address of the requested 32-bit word |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |
| seg_valid_o | output | 1 | Segment valid |
| seg_ready_i | input | 1 | Consumer accepts the segment |
| seg_addr_o | output | 31 | Segment start address |
| seg_len_o | output | 28 | Segment length in bytes |
| seg_last_o | output | 1 | Segment comes from the final descriptor |
| done_o | output | 1 | One-cycle pulse: list ended on its final mark |
| error_o | output | 1 | One-cycle pulse: entry limit used up without a final mark |

## Verification
The checks take for granted that the memory returns exactly one response per accepted request and never a response with no request pending; the bench memory model keeps a single pending-request slot and answers it once after a latency of zero to two cycles. They also assume `seg_ready_i` may toggle freely but the consumer does not depend on seeing a segment before it is offered. The sweep varies the base address, list length up to the limit, missing final marks, acceptance patterns on both handshakes and stray start pulses during a walk, all within those rules.

// File: rtl/sgl_pkg.sv
// Package: shared constants and types for the descriptor list walker.
// Assumes 32-bit descriptor words and byte addressing.
package sgl_pkg;

    localparam int WORD_W      = 32;
    localparam int SEG_LEN_W   = 28;
    localparam int SEG_ADDR_W  = 31;
    localparam int FINAL_BIT   = 31;
    localparam int ENTRY_BYTES = 8;
    localparam int WORD_BYTES  = 4;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ASK_LEN,
        WS_GET_LEN,
        WS_ASK_ADR,
        WS_GET_ADR,
        WS_OFFER
    } walk_state_e;

    typedef struct packed {
        logic                  is_final;
        logic [SEG_LEN_W-1:0]  len;
        logic [SEG_ADDR_W-1:0] addr;
    } segment_t;

endpackage

// File: rtl/sgl_desc_decode.sv
// Module: sgl_desc_decode
// Splits the two raw descriptor words into the segment fields.
// Assumes the words are already held stable by the caller.
module sgl_desc_decode
    import sgl_pkg::*;
(
    input  logic [WORD_W-1:0] len_word_i,
    input  logic [WORD_W-1:0] adr_word_i,
    output segment_t          seg_o
);

    logic [3:0] unused_bits;

    // Field extraction with the reserved bits dropped.
    always_comb begin
        seg_o.is_final = len_word_i[FINAL_BIT];
        seg_o.len      = len_word_i[SEG_LEN_W-1:0];
        seg_o.addr     = adr_word_i[SEG_ADDR_W-1:0];
    end

    assign unused_bits = {len_word_i[FINAL_BIT-1:SEG_LEN_W], adr_word_i[WORD_W-1]};

endmodule

// File: rtl/sgl_entry_counter.sv
// Module: sgl_entry_counter
// Counts accepted non-final entries of the current walk and flags when
// the entry now on offer is the last one the limit allows.
// Assumes clear and increment are never high together.
module sgl_entry_counter #(
    parameter int MAX_ENTRIES = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);

    localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
    localparam logic [CNT_W-1:0] LIMIT_IDX = CNT_W'(MAX_ENTRIES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Entry count register, zeroed by reset or a new walk.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign at_limit_o = (cnt_q == LIMIT_IDX);

endmodule

// File: rtl/sgl_walk_fsm.sv
// Module: sgl_walk_fsm
// Sequences the reads of each descriptor (length word, then address word),
// holds the raw words, offers the segment and decides between next entry,
// done and error. Assumes one response per accepted request.
module sgl_walk_fsm
    import sgl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_data_i,
    output logic [WORD_W-1:0] len_word_o,
    output logic [WORD_W-1:0] adr_word_o,
    output logic              seg_valid_o,
    input  logic              seg_ready_i,
    input  logic              seg_final_i,
    input  logic              at_limit_i,
    output logic              cnt_clr_o,
    output logic              cnt_inc_o,
    output logic              done_o,
    output logic              error_o
);

    localparam logic [ADDR_W-1:0] STEP_WORD  = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP_ENTRY = ADDR_W'(ENTRY_BYTES);

    walk_state_e       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [WORD_W-1:0] len_word_q, adr_word_q;
    logic              done_q, error_q;
    logic              take_start, seg_taken;

    assign take_start = (state_q == WS_IDLE) && start_i;
    assign seg_taken  = (state_q == WS_OFFER) && seg_ready_i;

    // Next-state selection for the walk sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:    if (start_i)         state_d = WS_ASK_LEN;
            WS_ASK_LEN: if (mem_req_ready_i) state_d = WS_GET_LEN;
            WS_GET_LEN: if (mem_rsp_valid_i) state_d = WS_ASK_ADR;
            WS_ASK_ADR: if (mem_req_ready_i) state_d = WS_GET_ADR;
            WS_GET_ADR: if (mem_rsp_valid_i) state_d = WS_OFFER;
            WS_OFFER: begin
                if (seg_ready_i) begin
                    if (seg_final_i || at_limit_i) state_d = WS_IDLE;
                    else                           state_d = WS_ASK_LEN;
                end
            end
            default:                         state_d = WS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= WS_IDLE;
        else         state_q <= state_d;
    end

    // Descriptor pointer: loaded on start, stepped past each non-final entry.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (take_start) begin
            ptr_q <= base_addr_i;
        end else if (seg_taken && !seg_final_i && !at_limit_i) begin
            ptr_q <= ptr_q + STEP_ENTRY;
        end
    end

    // Capture of the two descriptor words as their responses arrive.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            len_word_q <= '0;
            adr_word_q <= '0;
        end else begin
            if (state_q == WS_GET_LEN && mem_rsp_valid_i) len_word_q <= mem_rsp_data_i;
            if (state_q == WS_GET_ADR && mem_rsp_valid_i) adr_word_q <= mem_rsp_data_i;
        end
    end

    // One-cycle completion pulses, raised after the closing handshake.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            done_q  <= 1'b0;
            error_q <= 1'b0;
        end else begin
            done_q  <= seg_taken && seg_final_i;
            error_q <= seg_taken && !seg_final_i && at_limit_i;
        end
    end

    assign mem_req_valid_o = (state_q == WS_ASK_LEN) || (state_q == WS_ASK_ADR);
    assign mem_req_addr_o  = (state_q == WS_ASK_ADR) ? (ptr_q + STEP_WORD) : ptr_q;
    assign seg_valid_o     = (state_q == WS_OFFER);
    assign len_word_o      = len_word_q;
    assign adr_word_o      = adr_word_q;
    assign cnt_clr_o       = take_start;
    assign cnt_inc_o       = seg_taken && !seg_final_i;
    assign done_o          = done_q;
    assign error_o         = error_q;

endmodule

// File: rtl/sgl_walker.sv
// Module: sgl_walker (top)
// Walks a scatter-gather descriptor list in memory and emits one segment
// per entry. Assumes an in-order memory that answers each accepted read
// exactly once; the consumer discards all segments of a walk ending in error.
module sgl_walker
    import sgl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int MAX_ENTRIES = 256
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [ADDR_W-1:0]     base_addr_i,
    output logic                  mem_req_valid_o,
    input  logic                  mem_req_ready_i,
    output logic [ADDR_W-1:0]     mem_req_addr_o,
    input  logic                  mem_rsp_valid_i,
    input  logic [WORD_W-1:0]     mem_rsp_data_i,
    output logic                  seg_valid_o,
    input  logic                  seg_ready_i,
    output logic [SEG_ADDR_W-1:0] seg_addr_o,
    output logic [SEG_LEN_W-1:0]  seg_len_o,
    output logic                  seg_last_o,
    output logic                  done_o,
    output logic                  error_o
);

    logic [WORD_W-1:0] len_word, adr_word;
    segment_t          seg;
    logic              at_limit, cnt_clr, cnt_inc;

    sgl_walk_fsm #(
        .ADDR_W(ADDR_W)
    ) fsm_i (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .start_i         (start_i),
        .base_addr_i     (base_addr_i),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .len_word_o      (len_word),
        .adr_word_o      (adr_word),
        .seg_valid_o     (seg_valid_o),
        .seg_ready_i     (seg_ready_i),
        .seg_final_i     (seg.is_final),
        .at_limit_i      (at_limit),
        .cnt_clr_o       (cnt_clr),
        .cnt_inc_o       (cnt_inc),
        .done_o          (done_o),
        .error_o         (error_o)
    );

    sgl_desc_decode decode_i (
        .len_word_i (len_word),
        .adr_word_i (adr_word),
        .seg_o      (seg)
    );

    sgl_entry_counter #(
        .MAX_ENTRIES(MAX_ENTRIES)
    ) count_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (cnt_clr),
        .inc_i      (cnt_inc),
        .at_limit_o (at_limit)
    );

    assign seg_addr_o = seg.addr;
    assign seg_len_o  = seg.len;
    assign seg_last_o = seg.is_final;

endmodule

// File: rtl/sgl_walker_chk.sv
// Module: sgl_walker_chk
// Port-level protocol checks for sgl_walker, attached by bind below.
// Assumes the memory answers only requests it accepted.
module sgl_walker_chk #(
    parameter int ADDR_W      = 32,
    parameter int MAX_ENTRIES = 256
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [ADDR_W-1:0] mem_req_addr_o,
    input logic              mem_rsp_valid_i,
    input logic [31:0]       mem_rsp_data_i,
    input logic              seg_valid_o,
    input logic              seg_ready_i,
    input logic [30:0]       seg_addr_o,
    input logic [27:0]       seg_len_o,
    input logic              seg_last_o,
    input logic              done_o,
    input logic              error_o
);

    localparam int NC_W = $clog2(MAX_ENTRIES + 2);

    logic            was_rst;
    logic            pending_q;
    logic [NC_W-1:0] nonfinal_q;
    logic [ADDR_W+32:0] unused_in;

    assign unused_in = {start_i, base_addr_i, mem_rsp_data_i};

    // Remembers that the previous edge saw reset.
    always_ff @(posedge clk_i) was_rst <= !rst_ni;

    // Tracks an accepted, unanswered memory read.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                             pending_q <= 1'b0;
        else if (mem_req_valid_o && mem_req_ready_i) pending_q <= 1'b1;
        else if (mem_rsp_valid_i)                pending_q <= 1'b0;
    end

    // Counts accepted non-final segments of the current walk.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || done_o || error_o) nonfinal_q <= '0;
        else if (seg_valid_o && seg_ready_i && !seg_last_o) nonfinal_q <= nonfinal_q + NC_W'(1);
    end

    // R1: quiet outputs in the first cycle out of reset.
    always_ff @(posedge clk_i) begin
        if (rst_ni && was_rst) begin
            a_r1_quiet_after_reset: assert (!mem_req_valid_o && !seg_valid_o && !done_o && !error_o)
                else $error("a_r1_quiet_after_reset");
        end
    end

    a_r4_done_follows_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_valid_o && seg_ready_i && seg_last_o |=> done_o && !error_o);

    a_r4_done_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(seg_valid_o && seg_ready_i && seg_last_o));

    a_r5_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o)
            && $stable(seg_len_o) && $stable(seg_last_o));

    a_r5_no_fetch_while_offering: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seg_valid_o |-> !mem_req_valid_o);

    a_r7_error_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        error_o |-> $past(seg_valid_o && seg_ready_i && !seg_last_o));

    a_r7_within_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nonfinal_q <= NC_W'(MAX_ENTRIES));

    a_r9_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pending_q |-> !mem_req_valid_o);

    a_r9_request_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

endmodule

bind sgl_walker sgl_walker_chk #(
    .ADDR_W      (ADDR_W),
    .MAX_ENTRIES (MAX_ENTRIES)
) chk_i (.*);

// File: tb/sgl_walker_tb_top.sv
// Bench: sweeps list lengths, missing final marks, base addresses and
// handshake patterns on a walker with a small entry limit.
module sgl_walker_tb_top;

    localparam int AW   = 32;
    localparam int MAXE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          req_valid, req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic          rsp_valid = 1'b0;
    logic [31:0]   rsp_data = '0;
    logic          seg_valid, seg_ready = 1'b0;
    logic [30:0]   seg_addr;
    logic [27:0]   seg_len;
    logic          seg_last, done, err;

    always #5 clk = ~clk;

    sgl_walker #(.ADDR_W(AW), .MAX_ENTRIES(MAXE)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
        .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
        .seg_valid_o(seg_valid), .seg_ready_i(seg_ready), .seg_addr_o(seg_addr),
        .seg_len_o(seg_len), .seg_last_o(seg_last), .done_o(done), .error_o(err));

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] mem [0:255];

    int cyc = 0, ready_mode = 0, mem_mode = 0, lat = 0;
    bit active = 0;
    logic [AW-1:0] base_q = '0;
    string addr_tag = "R2";
    int exp_segs = 0, exp_reqs = 0, got_segs = 0, got_reqs = 0, got_done = 0, got_err = 0;
    bit exp_done = 0, exp_err = 0, want_done = 0, want_err = 0;
    bit pend = 0; int cd = 0; logic [AW-1:0] rsp_addr = '0;
    bit prev_stall = 0; logic [30:0] prev_addr; logic [27:0] prev_len; logic prev_last;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int widx(input logic [AW-1:0] a);
        return int'((a >> 2) & 32'hFF);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // Memory model, consumer model and port monitor, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (active && req_valid && pend)
            check(0, "R9", "request raised with a read outstanding", 1, 0);
        rsp_valid = 1'b0;
        if (pend) begin
            if (cd == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = mem[widx(rsp_addr)];
                pend = 0;
            end else cd--;
        end
        req_ready = (mem_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        seg_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? ((cyc % 2) == 0) : ((cyc % 5) == 4);
        if (active) begin
            if (want_done || done) check(done == want_done, "R4", "done_o pulse", done, want_done);
            if (want_err || err)   check(err == want_err, "R7", "error_o pulse", err, want_err);
            if (done) got_done++;
            if (err)  got_err++;
            want_done = 0; want_err = 0;
            if (prev_stall)
                check(seg_valid && seg_addr == prev_addr && seg_len == prev_len && seg_last == prev_last,
                      "R5", "segment held while stalled", {seg_valid, seg_len}, {1'b1, prev_len});
            if (seg_valid && req_valid) check(0, "R5", "fetch during offer", 1, 0);
            if (req_valid && req_ready) begin
                check(req_addr == base_q + AW'(4 * got_reqs), addr_tag, "request address",
                      req_addr, base_q + AW'(4 * got_reqs));
                check(got_reqs < exp_reqs, exp_err ? "R7" : "R4", "request count", got_reqs + 1, exp_reqs);
                pend = 1; cd = lat; rsp_addr = req_addr;
                got_reqs++;
            end
            if (seg_valid && seg_ready) begin
                logic [31:0] lw, aw;
                lw = mem[widx(base_q + AW'(8 * got_segs))];
                aw = mem[widx(base_q + AW'(8 * got_segs + 4))];
                check(seg_len == lw[27:0], (lw[27:0] == 0) ? "R6" : "R3", "segment length", seg_len, lw[27:0]);
                check(seg_addr == aw[30:0], "R3", "segment address", seg_addr, aw[30:0]);
                check(seg_last == lw[31], "R4", "final mark", seg_last, lw[31]);
                check(got_segs < exp_segs, "R5", "segment count", got_segs + 1, exp_segs);
                if (got_segs == exp_segs - 1) begin
                    want_done = exp_done;
                    want_err  = exp_err;
                end
                got_segs++;
            end
            prev_stall = seg_valid && !seg_ready;
            prev_addr = seg_addr; prev_len = seg_len; prev_last = seg_last;
        end
    end

    // One walk: n entries ending in a final mark, or none marked (error case).
    task automatic run_walk(input int seed, input int n, input bit with_final);
        logic [AW-1:0] b;
        b = {seed[3:0], 28'h0} | AW'((seed * 72) & 32'h3F8);
        for (int k = 0; k <= MAXE; k++) begin
            logic [27:0] l28;
            logic        fin;
            l28 = (((seed + k) % 4) == 1) ? 28'h0 : 28'((seed * 977 + k * 131 + 1));
            fin = with_final ? (k == n - 1) : (k == MAXE);
            mem[widx(b + AW'(8 * k))]     = {fin, 3'(seed + k), l28};
            mem[widx(b + AW'(8 * k + 4))] = {1'(seed + k), 31'(seed * 4096 + k * 64 + 3)};
        end
        exp_segs = with_final ? n : MAXE;
        exp_reqs = 2 * exp_segs;
        exp_done = with_final; exp_err = !with_final;
        got_segs = 0; got_reqs = 0; got_done = 0; got_err = 0;
        ready_mode = seed % 3; mem_mode = seed % 2; lat = seed % 3;
        addr_tag = (seed % 2 == 1) ? "R8" : "R2";
        base_q = b; prev_stall = 0; active = 1;
        @(negedge clk); start = 1'b1; base_addr = b;
        @(negedge clk); start = 1'b0; base_addr = ~b;
        if (seed % 2 == 1) begin
            @(negedge clk); start = 1'b1; base_addr = b ^ 32'h100;
            @(negedge clk); start = 1'b0;
        end
        for (int t = 0; t < 2000 && (got_done + got_err) == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(got_segs == exp_segs, "R5", "segments per walk", got_segs, exp_segs);
        check(got_reqs == exp_reqs, with_final ? "R4" : "R7", "reads per walk", got_reqs, exp_reqs);
        check(got_done == int'(exp_done), "R4", "done pulses", got_done, exp_done);
        check(got_err == int'(exp_err), "R7", "error pulses", got_err, exp_err);
        if (seed % 2 == 1)
            check(got_done + got_err == 1, "R8", "single walk despite stray start", got_done + got_err, 1);
        active = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!req_valid && !seg_valid && !done && !err, "R1", "outputs during reset",
              {req_valid, seg_valid, done, err}, 0);
        start = 1'b1;
        @(negedge clk); rst_n = 1'b1; start = 1'b0;
        check(!req_valid && !seg_valid && !done && !err, "R1", "outputs after reset",
              {req_valid, seg_valid, done, err}, 0);
        for (int seed = 0; seed < 12; seed++) begin
            for (int n = 1; n <= MAXE; n++) run_walk(seed, n, 1'b1);
            run_walk(seed, 0, 1'b0);
        end
        finish_run();
    end

endmodule